// File: doc/BRIEF.md
# UART Register Bank and Address Decoder

This block is the byte-wide register front end of a UART with the classic eight-offset register layout. A host writes and reads it over a simple synchronous bus made of a 3-bit offset, write data, read data, and one-cycle read and write strobes. It decodes each access and turns it into one of three things: a load of a local register, a strobe towards an external FIFO or interrupt unit, or a selection of read data.

The block itself stores four registers: line control, modem control, and the two divisor bytes. Bit 7 of line control is the divisor access bit. While it is set, offsets 0 and 1 reach the divisor bytes instead of the data path and the interrupt enable register. The line control fields are decoded into word length, stop-bit and parity outputs for a separate serializer. Line control also drives a break override on the transmit line.

Modem control drives four active-low modem outputs. Its loopback bit folds the transmit line and the modem outputs back onto the receive side. Interrupt enable, interrupt identification, line status and modem status are held outside the block and only multiplexed here.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line control, modem control and both divisor bytes are zero. In that state data_bits_o=5, stop_o=0, parity_o=0, div_o=0, and dtr_no, rts_no, out1_no and out2_no are all 1.
- R2: With the divisor access bit (line control bit 7) clear, a write to offset 0 raises tx_push_o in the same cycle. A read of offset 0 raises rx_pop_o in the same cycle and returns rx_data_i on rdata_o in the following cycle. wr_data_o always equals wdata_i.
- R3: With line control bit 7 set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. div_o = {high, low}. Such accesses raise none of tx_push_o, rx_pop_o or ier_wr_o.
- R4: With bit 7 clear, a write to offset 1 raises ier_wr_o in the same cycle, and a read of offset 1 returns ier_i.
- R5: Offset 2 reads iir_i and a write to it raises fcr_wr_o. Offsets 5 and 6 read lsr_i and msr_i, and offset 7 reads 0. Writes to offsets 5, 6 and 7 change no register and raise no strobe.
- R6: Offset 3 reads and writes all 8 bits of line control. Offset 4 reads and writes modem control bits 4:0, and bits 7:5 read as 0. Read data appears one cycle after rd_i and holds until the next read.
- R7: data_bits_o = 5 + line control bits 1:0.
- R8: stop_o is 0 (one stop bit) when line control bit 2 is 0. When bit 2 is 1, stop_o is 1 (one and a half) if bits 1:0 are 00, and 2 (two) otherwise.
- R9: parity_o is 0 (none) when line control bit 3 is 0. When bit 3 is 1, bits 5:4 map 00→1 odd, 01→2 even, 10→3 mark, 11→4 space.
- R10: While line control bit 6 is set, the internal transmit line is 0 whatever ser_txd_i is. Outside loopback, txd_o equals that line.
- R11: Outside loopback, dtr_no, rts_no, out1_no and out2_no are the inverses of modem control bits 0, 1, 2 and 3. cts_o, dsr_o, ri_o and dcd_o are the inverses of the matching pins, and ser_rxd_o equals rxd_i.
- R12: With modem control bit 4 set, txd_o and the four modem outputs are 1 and ser_rxd_o equals the internal transmit line. In this mode cts_o=bit 1, dsr_o=bit 0, ri_o=bit 2 and dcd_o=bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data, registered |
| rx_data_i | input | 8 | Head of receive FIFO |
| rx_pop_o | output | 1 | Receive FIFO pop |
| tx_push_o | output | 1 | Transmit FIFO push |
| wr_data_o | output | 8 | Data for push, interrupt-enable and FIFO-control writes |
| ier_i | input | 8 | External interrupt enable register |
| ier_wr_o | output | 1 | Interrupt enable write strobe |
| fcr_wr_o | output | 1 | FIFO control write strobe |
| iir_i | input | 8 | Interrupt identification value |
| lsr_i | input | 8 | Line status value |
| msr_i | input | 8 | Modem status value |
| div_o | output | 16 | Baud divisor |
| data_bits_o | output | 4 | Word length 5..8 |
| stop_o | output | 2 | Stop mode 0/1/2 |
| parity_o | output | 3 | Parity mode 0..4 |
| ser_txd_i | input | 1 | Serializer output |
| txd_o | output | 1 | Transmit pin |
| rxd_i | input | 1 | Receive pin |
| ser_rxd_o | output | 1 | Line to deserializer |
| cts_ni | input | 1 | Clear-to-send pin, active low |
| dsr_ni | input | 1 | Data-set-ready pin, active low |
| ri_ni | input | 1 | Ring pin, active low |
| dcd_ni | input | 1 | Carrier-detect pin, active low |
| cts_o | output | 1 | Clear-to-send to status logic |
| dsr_o | output | 1 | Data-set-ready to status logic |
| ri_o | output | 1 | Ring to status logic |
| dcd_o | output | 1 | Carrier-detect to status logic |
| dtr_no | output | 1 | Terminal-ready pin, active low |
| rts_no | output | 1 | Request-to-send pin, active low |
| out1_no | output | 1 | General output 1, active low |
| out2_no | output | 1 | General output 2, active low |

## Verification
A wrong divisor access bit shows up in the same cycle as the next access to offset 0 or 1. A FIFO strobe fires where it must not, or fails to fire, and the read data taken one cycle later comes from the wrong source. A corrupted line control or modem control value shows at once on the combinational format outputs and modem outputs. The bench therefore compares every static output after each access. Loopback and break faults show on txd_o and ser_rxd_o as soon as the serializer and pin inputs are toggled.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;
  localparam int NREG   = 4;
  localparam int MCR_W  = 5;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IDF  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LINE = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MODM = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSTS = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MSTS = 3'd6;

  // stored register indices
  localparam int RI_LINE = 0;
  localparam int RI_MODM = 1;
  localparam int RI_DIVL = 2;
  localparam int RI_DIVH = 3;

  localparam int LC_DIVACC = 7;
  localparam int LC_BRK    = 6;
  localparam int MC_LOOP   = 4;

  typedef enum logic [2:0] {PAR_NONE, PAR_ODD, PAR_EVEN, PAR_MARK, PAR_SPACE} par_mode_e;
  typedef enum logic [1:0] {STOP_ONE, STOP_ONE_HALF, STOP_TWO} stop_mode_e;
  typedef enum logic [3:0] {
    RS_RXD, RS_IEN, RS_IDF, RS_LINE, RS_MODM, RS_LSTS, RS_MSTS, RS_DIVL, RS_DIVH, RS_ZERO
  } rd_src_e;

  typedef struct packed {
    logic tx_push;
    logic rx_pop;
    logic ien_wr;
    logic fcr_wr;
  } strobe_t;

  function automatic logic [REG_W-1:0] reg_mask(int idx);
    return (idx == RI_MODM) ? REG_W'((1 << MCR_W) - 1) : {REG_W{1'b1}};
  endfunction
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              divacc_i,
  output strobe_t           stb_o,
  output logic [NREG-1:0]   we_o,
  output rd_src_e           src_o
);
  always_comb begin
    stb_o = '0;
    we_o  = '0;
    src_o = RS_ZERO;
    unique case (addr_i)
      OFS_DATA: begin
        if (divacc_i) begin
          we_o[RI_DIVL] = wr_i;
          src_o         = RS_DIVL;
        end else begin
          stb_o.tx_push = wr_i;
          stb_o.rx_pop  = rd_i;
          src_o         = RS_RXD;
        end
      end
      OFS_IEN: begin
        if (divacc_i) begin
          we_o[RI_DIVH] = wr_i;
          src_o         = RS_DIVH;
        end else begin
          stb_o.ien_wr = wr_i;
          src_o        = RS_IEN;
        end
      end
      OFS_IDF: begin
        stb_o.fcr_wr = wr_i;
        src_o        = RS_IDF;
      end
      OFS_LINE: begin
        we_o[RI_LINE] = wr_i;
        src_o         = RS_LINE;
      end
      OFS_MODM: begin
        we_o[RI_MODM] = wr_i;
        src_o         = RS_MODM;
      end
      OFS_LSTS: src_o = RS_LSTS;
      OFS_MSTS: src_o = RS_MSTS;
      default:  src_o = RS_ZERO;
    endcase
  end
endmodule

// File: rtl/uart_rb_regs.sv
module uart_rb_regs
  import uart_rb_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NREG-1:0]            we_i,
  input  logic [REG_W-1:0]           wdata_i,
  output logic [NREG-1:0][REG_W-1:0] q_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [REG_W-1:0] MASK = reg_mask(g);
    logic [REG_W-1:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (we_i[g]) q <= wdata_i & MASK;
    end
    assign q_o[g] = q;

    // R3, R6: a write loads the masked byte; other cycles keep the value
    assert_reg_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i[g] |=> q_o[g] == ($past(wdata_i) & MASK));
    assert_reg_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i[g] |=> $stable(q_o[g]));
  end
endmodule

// File: rtl/uart_rb_line.sv
module uart_rb_line
  import uart_rb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [6:0]       lcr_i,
  input  logic [MCR_W-1:0] mcr_i,
  input  logic             ser_txd_i,
  input  logic             rxd_i,
  input  logic             cts_ni,
  input  logic             dsr_ni,
  input  logic             ri_ni,
  input  logic             dcd_ni,
  output logic [3:0]       data_bits_o,
  output stop_mode_e       stop_o,
  output par_mode_e        parity_o,
  output logic             txd_o,
  output logic             ser_rxd_o,
  output logic             cts_o,
  output logic             dsr_o,
  output logic             ri_o,
  output logic             dcd_o,
  output logic             dtr_no,
  output logic             rts_no,
  output logic             out1_no,
  output logic             out2_no
);
  logic loop, tx_line;

  assign data_bits_o = 4'd5 + {2'b00, lcr_i[1:0]};

  always_comb begin
    if (!lcr_i[2])              stop_o = STOP_ONE;
    else if (lcr_i[1:0] == 2'b00) stop_o = STOP_ONE_HALF;
    else                        stop_o = STOP_TWO;
  end

  always_comb begin
    if (!lcr_i[3]) parity_o = PAR_NONE;
    else begin
      unique case (lcr_i[5:4])
        2'b00:   parity_o = PAR_ODD;
        2'b01:   parity_o = PAR_EVEN;
        2'b10:   parity_o = PAR_MARK;
        default: parity_o = PAR_SPACE;
      endcase
    end
  end

  assign loop    = mcr_i[MC_LOOP];
  assign tx_line = ser_txd_i & ~lcr_i[LC_BRK];

  assign txd_o     = loop | tx_line;
  assign ser_rxd_o = loop ? tx_line : rxd_i;

  assign dtr_no  = loop | ~mcr_i[0];
  assign rts_no  = loop | ~mcr_i[1];
  assign out1_no = loop | ~mcr_i[2];
  assign out2_no = loop | ~mcr_i[3];

  assign cts_o = loop ? mcr_i[1] : ~cts_ni;
  assign dsr_o = loop ? mcr_i[0] : ~dsr_ni;
  assign ri_o  = loop ? mcr_i[2] : ~ri_ni;
  assign dcd_o = loop ? mcr_i[3] : ~dcd_ni;

  assert_break_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcr_i[LC_BRK] && !loop) |-> !txd_o);
  assert_loop_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop |-> (txd_o && dtr_no && rts_no && out1_no && out2_no));
  assert_loop_route_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop && lcr_i[LC_BRK]) |-> !ser_rxd_o);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [REG_W-1:0]  rx_data_i,
  output logic              rx_pop_o,
  output logic              tx_push_o,
  output logic [REG_W-1:0]  wr_data_o,
  input  logic [REG_W-1:0]  ier_i,
  output logic              ier_wr_o,
  output logic              fcr_wr_o,
  input  logic [REG_W-1:0]  iir_i,
  input  logic [REG_W-1:0]  lsr_i,
  input  logic [REG_W-1:0]  msr_i,
  output logic [2*REG_W-1:0] div_o,
  output logic [3:0]        data_bits_o,
  output logic [1:0]        stop_o,
  output logic [2:0]        parity_o,
  input  logic              ser_txd_i,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              ser_rxd_o,
  input  logic              cts_ni,
  input  logic              dsr_ni,
  input  logic              ri_ni,
  input  logic              dcd_ni,
  output logic              cts_o,
  output logic              dsr_o,
  output logic              ri_o,
  output logic              dcd_o,
  output logic              dtr_no,
  output logic              rts_no,
  output logic              out1_no,
  output logic              out2_no
);
  strobe_t                   stb;
  logic [NREG-1:0]           we;
  rd_src_e                   src;
  logic [NREG-1:0][REG_W-1:0] regs;
  logic [REG_W-1:0]          lcr, rd_mux, rdata_q;
  logic [MCR_W-1:0]          mcr;
  stop_mode_e                stop_e;
  par_mode_e                 par_e;

  assign lcr = regs[RI_LINE];
  assign mcr = regs[RI_MODM][MCR_W-1:0];

  uart_rb_decode u_dec (
    .addr_i  (addr_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .divacc_i(lcr[LC_DIVACC]),
    .stb_o   (stb),
    .we_o    (we),
    .src_o   (src)
  );

  uart_rb_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .wdata_i(wdata_i),
    .q_o    (regs)
  );

  uart_rb_line u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lcr_i      (lcr[6:0]),
    .mcr_i      (mcr),
    .ser_txd_i  (ser_txd_i),
    .rxd_i      (rxd_i),
    .cts_ni     (cts_ni),
    .dsr_ni     (dsr_ni),
    .ri_ni      (ri_ni),
    .dcd_ni     (dcd_ni),
    .data_bits_o(data_bits_o),
    .stop_o     (stop_e),
    .parity_o   (par_e),
    .txd_o      (txd_o),
    .ser_rxd_o  (ser_rxd_o),
    .cts_o      (cts_o),
    .dsr_o      (dsr_o),
    .ri_o       (ri_o),
    .dcd_o      (dcd_o),
    .dtr_no     (dtr_no),
    .rts_no     (rts_no),
    .out1_no    (out1_no),
    .out2_no    (out2_no)
  );

  assign stop_o   = stop_e;
  assign parity_o = par_e;

  always_comb begin
    unique case (src)
      RS_RXD:  rd_mux = rx_data_i;
      RS_IEN:  rd_mux = ier_i;
      RS_IDF:  rd_mux = iir_i;
      RS_LINE: rd_mux = lcr;
      RS_MODM: rd_mux = REG_W'(mcr);
      RS_LSTS: rd_mux = lsr_i;
      RS_MSTS: rd_mux = msr_i;
      RS_DIVL: rd_mux = regs[RI_DIVL];
      RS_DIVH: rd_mux = regs[RI_DIVH];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign rx_pop_o  = stb.rx_pop;
  assign tx_push_o = stb.tx_push;
  assign ier_wr_o  = stb.ien_wr;
  assign fcr_wr_o  = stb.fcr_wr;
  assign wr_data_o = wdata_i;
  assign div_o     = {regs[RI_DIVH], regs[RI_DIVL]};

  assert_pop_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |=> rdata_o == $past(rx_data_i));
  assert_divacc_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcr[LC_DIVACC] && addr_i <= OFS_IEN) |-> !(tx_push_o || rx_pop_o || ier_wr_o));
  assert_divlo_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && lcr[LC_DIVACC] && addr_i == OFS_DATA) |=> rdata_o == $past(div_o[REG_W-1:0]));
  assert_hole_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd7) |=> rdata_o == '0);
  assert_read_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_push_o, ier_wr_o, fcr_wr_o}));
endmodule

// File: tb/tb_uart_regbank.sv
module tb_uart_regbank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rx_data = '0, ier = '0, iir = '0, lsr = '0, msr = '0;
  logic rd = 0, wr = 0, ser_txd = 1, rxd = 1, cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic [7:0] rdata, wr_data;
  logic rx_pop, tx_push, ier_wr, fcr_wr, txd, ser_rxd, cts, dsr, ri, dcd;
  logic dtr_n, rts_n, out1_n, out2_n;
  logic [15:0] div;
  logic [3:0] data_bits;
  logic [1:0] stop;
  logic [2:0] parity;

  int n_chk = 0, n_fail = 0;
  logic [7:0] lcr_m = '0, mcr_m = '0, dll_m = '0, dlm_m = '0;

  always #10 clk = ~clk;

  uart_regbank dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .rd_i(rd), .wr_i(wr),
    .rdata_o(rdata), .rx_data_i(rx_data), .rx_pop_o(rx_pop), .tx_push_o(tx_push),
    .wr_data_o(wr_data), .ier_i(ier), .ier_wr_o(ier_wr), .fcr_wr_o(fcr_wr),
    .iir_i(iir), .lsr_i(lsr), .msr_i(msr), .div_o(div), .data_bits_o(data_bits),
    .stop_o(stop), .parity_o(parity), .ser_txd_i(ser_txd), .txd_o(txd), .rxd_i(rxd),
    .ser_rxd_o(ser_rxd), .cts_ni(cts_n), .dsr_ni(dsr_n), .ri_ni(ri_n), .dcd_ni(dcd_n),
    .cts_o(cts), .dsr_o(dsr), .ri_o(ri), .dcd_o(dcd), .dtr_no(dtr_n), .rts_no(rts_n),
    .out1_no(out1_n), .out2_no(out2_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_par(input logic [7:0] l);
    if (!l[3]) return 3'd0;
    return 3'd1 + {1'b0, l[5:4]};
  endfunction

  function automatic logic [1:0] exp_stop(input logic [7:0] l);
    if (!l[2]) return 2'd0;
    return (l[1:0] == 2'b00) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return lcr_m[7] ? dll_m : rx_data;
      3'd1: return lcr_m[7] ? dlm_m : ier;
      3'd2: return iir;
      3'd3: return lcr_m;
      3'd4: return mcr_m;
      3'd5: return lsr;
      3'd6: return msr;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_static();
    logic lp, txl;
    lp  = mcr_m[4];
    txl = ser_txd & ~lcr_m[6];
    chk(data_bits == 4'd5 + {2'b0, lcr_m[1:0]}, "R7 data_bits", data_bits, 4'd5 + {2'b0, lcr_m[1:0]});
    chk(stop == exp_stop(lcr_m), "R8 stop", stop, exp_stop(lcr_m));
    chk(parity == exp_par(lcr_m), "R9 parity", parity, exp_par(lcr_m));
    chk(div == {dlm_m, dll_m}, "R3 div", div, {dlm_m, dll_m});
    chk(txd == (lp | txl), "R10 txd", txd, lp | txl);
    chk(ser_rxd == (lp ? txl : rxd), "R12 ser_rxd", ser_rxd, lp ? txl : rxd);
    chk({dtr_n, rts_n, out1_n, out2_n} == (lp ? 4'hF : ~{mcr_m[0], mcr_m[1], mcr_m[2], mcr_m[3]}),
        "R11 modem outs", {dtr_n, rts_n, out1_n, out2_n},
        lp ? 4'hF : ~{mcr_m[0], mcr_m[1], mcr_m[2], mcr_m[3]});
    chk({cts, dsr, ri, dcd} == (lp ? {mcr_m[1], mcr_m[0], mcr_m[2], mcr_m[3]} : ~{cts_n, dsr_n, ri_n, dcd_n}),
        "R12 modem ins", {cts, dsr, ri, dcd},
        lp ? {mcr_m[1], mcr_m[0], mcr_m[2], mcr_m[3]} : ~{cts_n, dsr_n, ri_n, dcd_n});
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    logic dl;
    @(negedge clk);
    addr = a; wdata = d; wr = 1;
    dl = lcr_m[7];
    #1;
    chk(tx_push == (a == 3'd0 && !dl), "R2 tx_push", tx_push, a == 3'd0 && !dl);
    chk(ier_wr == (a == 3'd1 && !dl), "R4 ier_wr", ier_wr, a == 3'd1 && !dl);
    chk(fcr_wr == (a == 3'd2), "R5 fcr_wr", fcr_wr, a == 3'd2);
    chk(wr_data == d, "R2 wr_data", wr_data, d);
    chk(!rx_pop, "R3 no pop on write", rx_pop, 0);
    @(posedge clk);
    case (a)
      3'd0: if (dl) dll_m = d;
      3'd1: if (dl) dlm_m = d;
      3'd3: lcr_m = d;
      3'd4: mcr_m = {3'b000, d[4:0]};
      default: ;
    endcase
    @(negedge clk);
    wr = 0;
    #1;
    check_static();
  endtask

  task automatic do_read(input logic [2:0] a);
    logic [7:0] e;
    @(negedge clk);
    addr = a; rd = 1;
    #1;
    e = exp_rd(a);
    chk(rx_pop == (a == 3'd0 && !lcr_m[7]), "R2 rx_pop", rx_pop, a == 3'd0 && !lcr_m[7]);
    chk(!tx_push && !ier_wr, "R3 no write strobe on read", {tx_push, ier_wr}, 0);
    @(posedge clk);
    @(negedge clk);
    rd = 0;
    rx_data = 8'h5A;
    #1;
    chk(rdata == e, "R6 rdata", rdata, e);
  endtask

  task automatic shake_inputs();
    @(negedge clk);
    {ser_txd, rxd, cts_n, dsr_n, ri_n, dcd_n} = 6'($urandom);
    {rx_data, ier} = 16'($urandom);
    {iir, lsr, msr} = 24'($urandom);
    #1;
    check_static();
  endtask

  bit done = 0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #35 rst_n = 1;
    #1;
    // R1: reset state
    chk(div == 16'h0 && data_bits == 4'd5 && stop == 2'd0 && parity == 3'd0, "R1 format", {div, data_bits, stop, parity}, {16'h0, 4'd5, 2'd0, 3'd0});
    chk({dtr_n, rts_n, out1_n, out2_n} == 4'hF, "R1 modem outs", {dtr_n, rts_n, out1_n, out2_n}, 4'hF);
    do_read(3'd3);
    do_read(3'd4);

    // R2, R3 directed: data path then divisor banking
    rx_data = 8'hC3;
    do_read(3'd0);
    do_write(3'd0, 8'h11);
    do_write(3'd3, 8'h83);
    do_write(3'd0, 8'h34);
    do_write(3'd1, 8'h12);
    do_read(3'd0);
    do_read(3'd1);
    do_write(3'd3, 8'h03);
    do_read(3'd0);
    do_read(3'd1);

    // R5: ignored writes leave every register intact
    do_write(3'd5, 8'hFF);
    do_write(3'd6, 8'hFF);
    do_write(3'd7, 8'hFF);
    do_read(3'd3);
    do_read(3'd4);
    do_read(3'd7);

    // R8: 1.5 stop at 5-bit words; R9 all parity codes
    do_write(3'd3, 8'h04);
    do_write(3'd3, 8'h0D);
    do_write(3'd3, 8'h1E);
    do_write(3'd3, 8'h2F);
    do_write(3'd3, 8'h3B);
    do_write(3'd3, 8'h30);

    // R10 break, R11/R12 modem and loopback
    do_write(3'd3, 8'h40);
    ser_txd = 1; #1; check_static();
    do_write(3'd4, 8'hEF);
    do_read(3'd4);
    for (int i = 0; i < 8; i++) shake_inputs();
    do_write(3'd4, 8'h1A);
    for (int i = 0; i < 8; i++) shake_inputs();
    do_write(3'd3, 8'h00);
    for (int i = 0; i < 8; i++) shake_inputs();

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom);
      d = 8'($urandom);
      case ($urandom % 3)
        0: do_write(a, d);
        1: do_read(a);
        default: shake_inputs();
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule